// File: doc/BRIEF.md
# Hot-Swap Circuit Breaker Sequencer

This block is the digital sequencer of a hot-swap power switch. It takes comparator flags from the analog front end and drives the controls of the external pass transistor and its retry timing capacitor. The flags are supply-regulator OK, enable, undervoltage, overvoltage, the two overcurrent levels, the two sense-line opens and the timing-capacitor thresholds. The controls are gate enable, strong and weak gate pull-downs, load discharge drive, a current-fault flag, and charge and discharge of the retry capacitor. All flags are active high and pass through a two-flop synchronizer, so every response carries two cycles of input latency.

After the regulator comes up, a power-on delay runs. The switch then turns on when enable rises, or at once if enable is already high at the end of the delay. Two overcurrent paths guard the switch.

- The slow path waits for the external primary-timer capacitor to fall below its low threshold. It then counts a default timer before it trips.
- The fast path trips without delay.

After a trip, the block recovers in one of two ways. In latched mode it waits for an enable low pulse. In auto-retry mode it runs a cool-off that is timed by the two thresholds of the retry capacitor. Undervoltage and overvoltage switch the load off and recover on their own. All durations are parameters counted in clock cycles.

Top module: `hs_breaker_seq`

## Requirements
- R1: While `vreg_ok_i` is low, every output is low and the sequencer is held at the start of its power-on delay. After `vreg_ok_i` rises, the gate stays off and the discharge output stays low for `POR_CYC` cycles.
- R2: Start-up (`gate_en_o`=1) happens in either of two cases. The first is when `enable_i` is already high as the power-on delay ends. The second is on a later rising edge of `enable_i`. While `uv_i` or `ov_i` is high, the gate is held off, and it turns on once both clear.
- R3: When `oc_pri_i` is high, nothing trips until `cpri_low_i` (1 = capacitor below its low threshold) goes high. The breaker then trips `POC_DEF_CYC` cycles later, plus input latency. If `oc_pri_i` drops before that, the sequence aborts.
- R4: A high `oc_sec_i` while the switch is on trips the breaker within three cycles.
- R5: On any trip, `gate_en_o` drops, and `gate_pd_strong_o`, `disch_o` and `ifault_o` go high.
- R6: With `retry_auto_i`=0, the trip stays latched until `enable_i` goes low. `ifault_o` then clears `CB_RST_CYC` cycles later. A rising edge of `enable_i` restarts the switch only if `enable_i` was low for at least `ENLPW_CYC` cycles.
- R7: With `retry_auto_i`=1, a trip asserts `retry_chg_o` and drops `retry_dis_o`. When `retry_hi_i` goes high, `ifault_o` clears, `retry_dis_o` returns and the gate stays off. When `retry_lo_i` goes high after that, the gate turns on again and `disch_o` falls.
- R8: `uv_i` or `ov_i` turns the gate off, raises `gate_pd_strong_o` and `disch_o`, and leaves `ifault_o` low. The switch recovers when both flags clear.
- R9: A high `open_load_i` or `open_gnd_i` trips the breaker in either retry mode, and the trip never auto-retries. It clears on an enable low or on loss of `vreg_ok_i`.
- R10: While `enable_i` is low after the power-on delay, with no trip and no voltage fault, the gate is off, `gate_pd_weak_o` is high and `disch_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vreg_ok_i | input | 1 | Internal regulator above its lockout threshold |
| enable_i | input | 1 | Switch enable |
| uv_i | input | 1 | Supply undervoltage flag |
| ov_i | input | 1 | Supply overvoltage flag |
| oc_pri_i | input | 1 | Primary overcurrent comparator |
| oc_sec_i | input | 1 | Secondary (fast) overcurrent comparator |
| open_load_i | input | 1 | Load-sense line open |
| open_gnd_i | input | 1 | Ground-sense line open |
| cpri_low_i | input | 1 | Primary timer capacitor below its low threshold |
| retry_auto_i | input | 1 | 1 = auto-retry, 0 = latched |
| retry_hi_i | input | 1 | Retry capacitor above its high threshold |
| retry_lo_i | input | 1 | Retry capacitor below its low threshold |
| gate_en_o | output | 1 | Gate drive enable |
| gate_pd_strong_o | output | 1 | Fault-mode strong gate pull-down |
| gate_pd_weak_o | output | 1 | Normal weak gate pull-down |
| disch_o | output | 1 | External discharge drive |
| ifault_o | output | 1 | Current/breaker fault flag |
| retry_chg_o | output | 1 | Weak charging source on retry capacitor |
| retry_dis_o | output | 1 | Strong sink on retry capacitor |

## Verification
The bench builds the block with a 40-cycle power-on delay, a 12-cycle primary default timer, a 5-cycle breaker reset delay and a 25-cycle minimum enable-low pulse. These short durations let one run cover every path: both power-on start cases, an enable pulse that is too short, the primary timer boundary on both sides, the primary abort, latched and auto-retry recovery, and sense-line faults under regulator loss. Because the timers are short, their boundaries can be sampled a few cycles on either side of the computed trip and clear cycles.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    S_POR,
    S_IDLE,
    S_RUN,
    S_TRIP,
    S_COOL,
    S_DRAIN,
    S_CLEAR
  } hs_state_e;

  typedef enum logic [1:0] {
    P_IDLE,
    P_CAP,
    P_TMR
  } pri_phase_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hs_pri_oc.sv
module hs_pri_oc
  import hs_pkg::*;
#(
  parameter int DEF_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic oc_i,
  input  logic cap_low_i,
  output logic trip_o
);
  localparam int CW = (DEF_CYC > 1) ? $clog2(DEF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEF_CYC - 1);

  pri_phase_e phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= P_IDLE;
      cnt_q   <= '0;
    end else if (!arm_i || !oc_i) begin
      phase_q <= P_IDLE;  // flag cleared: abort
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        P_IDLE: phase_q <= P_CAP;
        P_CAP: if (cap_low_i) begin
          phase_q <= P_TMR;
          cnt_q   <= '0;
        end
        P_TMR: if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        default: phase_q <= P_IDLE;
      endcase
    end
  end

  assign trip_o = arm_i && oc_i && (phase_q == P_TMR) && (cnt_q == LAST);

  assert_pri_needs_oc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> $past(oc_i));
  assert_pri_no_trip_waiting_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == P_CAP && !cap_low_i && DEF_CYC > 1) |=> !trip_o);
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int POR_CYC    = 812500,
  parameter int CB_RST_CYC = 625,
  parameter int ENLPW_CYC  = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vreg_s_i,
  input  logic en_s_i,
  input  logic uv_s_i,
  input  logic ov_s_i,
  input  logic oc_sec_s_i,
  input  logic open_load_s_i,
  input  logic open_gnd_s_i,
  input  logic retry_auto_s_i,
  input  logic retry_hi_s_i,
  input  logic retry_lo_s_i,
  input  logic pri_trip_i,
  output logic run_o,
  output logic gate_en_o,
  output logic gate_pd_strong_o,
  output logic gate_pd_weak_o,
  output logic disch_o,
  output logic ifault_o,
  output logic retry_chg_o,
  output logic retry_dis_o
);
  localparam int PW = $clog2(POR_CYC + 1);
  localparam int LW = $clog2(ENLPW_CYC + 1);
  localparam int RW = $clog2(CB_RST_CYC + 1);

  hs_state_e st_q, st_d;
  logic [PW-1:0] por_cnt_q;
  logic [LW-1:0] low_cnt_q;
  logic [RW-1:0] clr_cnt_q;
  logic en_q, sense_trip_q;
  logic start_ok, sense_hit, any_trip, vbad, live, brk_off, tripped;

  assign vbad      = uv_s_i || ov_s_i;
  assign sense_hit = open_load_s_i || open_gnd_s_i;
  assign any_trip  = oc_sec_s_i || pri_trip_i || sense_hit;
  assign start_ok  = en_s_i && !en_q && (low_cnt_q >= LW'(ENLPW_CYC));

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_POR:   if (por_cnt_q == PW'(POR_CYC - 1)) st_d = en_s_i ? S_RUN : S_IDLE;
      S_IDLE:  if (start_ok) st_d = S_RUN;
      S_RUN:   if (!en_s_i) st_d = S_IDLE;
               else if (any_trip) st_d = S_TRIP;
      S_TRIP:  if (!en_s_i) st_d = S_CLEAR;
               else if (retry_auto_s_i && !sense_trip_q) st_d = S_COOL;
      S_COOL:  if (!en_s_i) st_d = S_CLEAR;
               else if (retry_hi_s_i) st_d = S_DRAIN;
      S_DRAIN: if (!en_s_i) st_d = S_IDLE;
               else if (retry_lo_s_i) st_d = S_RUN;
      S_CLEAR: if (clr_cnt_q == RW'(CB_RST_CYC - 1)) st_d = S_IDLE;
      default: st_d = S_POR;
    endcase
    if (!vreg_s_i) st_d = S_POR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_POR;
      por_cnt_q    <= '0;
      low_cnt_q    <= '0;
      clr_cnt_q    <= '0;
      en_q         <= 1'b0;
      sense_trip_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= en_s_i;
      if (!vreg_s_i || st_q != S_POR) por_cnt_q <= '0;
      else por_cnt_q <= por_cnt_q + 1'b1;
      if (st_q == S_POR || en_s_i) low_cnt_q <= '0;
      else if (low_cnt_q != LW'(ENLPW_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
      if (st_q != S_CLEAR) clr_cnt_q <= '0;
      else clr_cnt_q <= clr_cnt_q + 1'b1;
      if (st_q == S_RUN && st_d == S_TRIP) sense_trip_q <= sense_hit;
      else if (st_q == S_POR || st_q == S_IDLE) sense_trip_q <= 1'b0;
    end
  end

  assign live    = (st_q != S_POR);
  assign tripped = (st_q == S_TRIP) || (st_q == S_COOL) || (st_q == S_CLEAR);
  assign brk_off = tripped || (st_q == S_DRAIN);

  assign run_o            = (st_q == S_RUN);
  assign gate_en_o        = run_o && !vbad;
  assign gate_pd_strong_o = brk_off || (live && vbad);
  assign gate_pd_weak_o   = live && !gate_en_o && !gate_pd_strong_o;
  assign disch_o          = live && !gate_en_o;
  assign ifault_o         = tripped;
  assign retry_chg_o      = (st_q == S_COOL);
  assign retry_dis_o      = live && (st_q != S_COOL);

  assert_vreg_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vreg_s_i |=> (!gate_en_o && !ifault_o && !disch_o));
  assert_sec_trip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RUN && vreg_s_i && en_s_i && oc_sec_s_i) |=> ifault_o);
  assert_trip_outputs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ifault_o) |-> (!gate_en_o && gate_pd_strong_o && disch_o));
  assert_latched_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifault_o && !retry_auto_s_i && en_s_i && vreg_s_i) |=> ifault_o);
  assert_retry_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_chg_o && retry_hi_s_i && en_s_i && vreg_s_i) |=> (!ifault_o && retry_dis_o));
endmodule

// File: rtl/hs_breaker_seq.sv
module hs_breaker_seq #(
  parameter int POR_CYC     = 812500,
  parameter int POC_DEF_CYC = 31250,
  parameter int CB_RST_CYC  = 625,
  parameter int ENLPW_CYC   = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vreg_ok_i,
  input  logic enable_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic oc_pri_i,
  input  logic oc_sec_i,
  input  logic open_load_i,
  input  logic open_gnd_i,
  input  logic cpri_low_i,
  input  logic retry_auto_i,
  input  logic retry_hi_i,
  input  logic retry_lo_i,
  output logic gate_en_o,
  output logic gate_pd_strong_o,
  output logic gate_pd_weak_o,
  output logic disch_o,
  output logic ifault_o,
  output logic retry_chg_o,
  output logic retry_dis_o
);
  localparam int NF = 12;

  logic [NF-1:0] raw, syn;
  logic run, pri_trip;

  assign raw = {vreg_ok_i, enable_i, uv_i, ov_i, oc_pri_i, oc_sec_i,
                open_load_i, open_gnd_i, cpri_low_i, retry_auto_i, retry_hi_i, retry_lo_i};

  hs_sync #(.W(NF)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  hs_pri_oc #(.DEF_CYC(POC_DEF_CYC)) i_pri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (run),
    .oc_i     (syn[7]),
    .cap_low_i(syn[3]),
    .trip_o   (pri_trip)
  );

  hs_ctrl #(
    .POR_CYC   (POR_CYC),
    .CB_RST_CYC(CB_RST_CYC),
    .ENLPW_CYC (ENLPW_CYC)
  ) i_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .vreg_s_i        (syn[11]),
    .en_s_i          (syn[10]),
    .uv_s_i          (syn[9]),
    .ov_s_i          (syn[8]),
    .oc_sec_s_i      (syn[6]),
    .open_load_s_i   (syn[5]),
    .open_gnd_s_i    (syn[4]),
    .retry_auto_s_i  (syn[2]),
    .retry_hi_s_i    (syn[1]),
    .retry_lo_s_i    (syn[0]),
    .pri_trip_i      (pri_trip),
    .run_o           (run),
    .gate_en_o       (gate_en_o),
    .gate_pd_strong_o(gate_pd_strong_o),
    .gate_pd_weak_o  (gate_pd_weak_o),
    .disch_o         (disch_o),
    .ifault_o        (ifault_o),
    .retry_chg_o     (retry_chg_o),
    .retry_dis_o     (retry_dis_o)
  );
endmodule

// File: tb/test_hs_breaker_seq.sv
module test_hs_breaker_seq;
  localparam int POR = 40;
  localparam int POC = 12;
  localparam int CBR = 5;
  localparam int EPW = 25;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vreg = 0, en = 0, uv = 0, ov = 0, ocp = 0, ocs = 0;
  logic ol = 0, og = 0, cap = 0, rauto = 0, rhi = 0, rlo = 0;
  logic gate, pds, pdw, disch, flt, rchg, rdis;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  hs_breaker_seq #(
    .POR_CYC(POR), .POC_DEF_CYC(POC), .CB_RST_CYC(CBR), .ENLPW_CYC(EPW)
  ) i_hs_breaker_seq (
    .clk_i(clk), .rst_ni(rst_ni), .vreg_ok_i(vreg), .enable_i(en), .uv_i(uv), .ov_i(ov),
    .oc_pri_i(ocp), .oc_sec_i(ocs), .open_load_i(ol), .open_gnd_i(og), .cpri_low_i(cap),
    .retry_auto_i(rauto), .retry_hi_i(rhi), .retry_lo_i(rlo),
    .gate_en_o(gate), .gate_pd_strong_o(pds), .gate_pd_weak_o(pdw), .disch_o(disch),
    .ifault_o(flt), .retry_chg_o(rchg), .retry_dis_o(rdis)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic restart();
    en = 0; wait_cyc(EPW + 5);
    en = 1; wait_cyc(5);
  endtask

  task automatic t_reset();
    wait_cyc(2);
    chk("R1", "gate in vreg low", gate, 0);
    chk("R1", "disch in vreg low", disch, 0);
    chk("R1", "fault in vreg low", flt, 0);
    chk("R1", "retry sink in vreg low", rdis, 0);
    vreg = 1; wait_cyc(20);
    chk("R1", "gate during por", gate, 0);
    chk("R1", "disch during por", disch, 0);
    wait_cyc(30);
    chk("R10", "gate enable low", gate, 0);
    chk("R10", "weak pd enable low", pdw, 1);
    chk("R10", "disch enable low", disch, 1);
    chk("R10", "retry sink idle", rdis, 1);
  endtask

  task automatic t_start();
    wait_cyc(30);
    en = 1; wait_cyc(5);
    chk("R2", "gate after enable edge", gate, 1);
    chk("R2", "disch off when on", disch, 0);
    en = 0; wait_cyc(4);
    chk("R10", "gate off on enable low", gate, 0);
    chk("R10", "weak pd on enable low", pdw, 1);
    wait_cyc(6);
    en = 1; wait_cyc(10);
    chk("R6", "short low pulse no start", gate, 0);
    restart();
    chk("R6", "long low pulse starts", gate, 1);
  endtask

  task automatic t_vbad();
    uv = 1; wait_cyc(4);
    chk("R8", "uv gate off", gate, 0);
    chk("R8", "uv strong pd", pds, 1);
    chk("R8", "uv disch", disch, 1);
    chk("R8", "uv no fault", flt, 0);
    uv = 0; wait_cyc(4);
    chk("R8", "uv recovery", gate, 1);
    ov = 1; wait_cyc(4);
    chk("R8", "ov gate off", gate, 0);
    chk("R8", "ov strong pd", pds, 1);
    ov = 0; wait_cyc(4);
    chk("R8", "ov recovery", gate, 1);
    en = 0; wait_cyc(EPW + 5);
    ov = 1; en = 1; wait_cyc(8);
    chk("R2", "start blocked by ov", gate, 0);
    ov = 0; wait_cyc(4);
    chk("R2", "start after ov clears", gate, 1);
  endtask

  task automatic t_sec();
    ocs = 1; wait_cyc(1); ocs = 0; wait_cyc(4);
    chk("R4", "secondary trips fast", flt, 1);
    chk("R5", "trip gate off", gate, 0);
    chk("R5", "trip strong pd", pds, 1);
    chk("R5", "trip disch", disch, 1);
    wait_cyc(40);
    chk("R6", "latched fault holds", flt, 1);
    chk("R6", "latched gate off", gate, 0);
    en = 0; wait_cyc(2);
    chk("R6", "fault before reset delay", flt, 1);
    wait_cyc(10);
    chk("R6", "fault cleared after reset delay", flt, 0);
    en = 1; wait_cyc(8);
    chk("R6", "no restart on short low", gate, 0);
    restart();
    chk("R6", "restart after full pulse", gate, 1);
  endtask

  task automatic t_pri();
    ocp = 1; wait_cyc(40);
    chk("R3", "no trip without cap low", flt, 0);
    chk("R3", "gate on while waiting", gate, 1);
    cap = 1; wait_cyc(POC);
    chk("R3", "no trip before default timer", flt, 0);
    wait_cyc(6);
    chk("R3", "trip after default timer", flt, 1);
    chk("R5", "primary trip gate off", gate, 0);
    ocp = 0; cap = 0;
    restart();
    chk("R6", "recover after primary trip", flt, 0);
    ocp = 1; cap = 1; wait_cyc(8);
    ocp = 0; wait_cyc(30);
    chk("R3", "abort when flag clears", flt, 0);
    chk("R3", "gate stays on after abort", gate, 1);
    cap = 0; wait_cyc(2);
  endtask

  task automatic t_open();
    rauto = 1;
    ol = 1; wait_cyc(4); ol = 0; wait_cyc(1);
    chk("R9", "open load trips", flt, 1);
    chk("R9", "open load gate off", gate, 0);
    rhi = 1; wait_cyc(10);
    chk("R9", "open trip no auto retry", flt, 1);
    chk("R9", "no retry charge on open trip", rchg, 0);
    rhi = 0; en = 0; wait_cyc(15);
    chk("R9", "open trip cleared by enable low", flt, 0);
    wait_cyc(EPW); en = 1; wait_cyc(5);
    chk("R9", "restart after open clear", gate, 1);
    og = 1; wait_cyc(4); og = 0; wait_cyc(1);
    chk("R9", "open gnd trips", flt, 1);
    vreg = 0; wait_cyc(4);
    chk("R9", "vreg loss clears open trip", flt, 0);
    chk("R1", "vreg loss gate off", gate, 0);
    vreg = 1; wait_cyc(POR + 8);
    chk("R2", "enable high at por end starts", gate, 1);
  endtask

  task automatic t_retry();
    ocs = 1; wait_cyc(1); ocs = 0; wait_cyc(5);
    chk("R7", "retry trip fault", flt, 1);
    chk("R7", "retry cap charging", rchg, 1);
    chk("R7", "retry sink released", rdis, 0);
    wait_cyc(10);
    chk("R7", "cool-off holds gate off", gate, 0);
    rhi = 1; wait_cyc(4);
    chk("R7", "fault clears at high threshold", flt, 0);
    chk("R7", "charge stops at high threshold", rchg, 0);
    chk("R7", "sink on at high threshold", rdis, 1);
    chk("R7", "gate still off draining", gate, 0);
    chk("R7", "disch high draining", disch, 1);
    rhi = 0; rlo = 1; wait_cyc(4);
    chk("R7", "gate back at low threshold", gate, 1);
    chk("R7", "disch low after retry", disch, 0);
    rlo = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1;
    t_reset();
    t_start();
    t_vbad();
    t_sec();
    t_pri();
    t_open();
    t_retry();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule